// File: doc/BRIEF.md
# I2C SCL Bit-Timing Generator

This block sets the SCL bit rhythm for an I2C master. A configuration word selects a prescale divisor and a gap count. The prescaler turns the peripheral clock into a slower internal step. Counted in those steps, one full SCL period is a fixed base of 20, plus eight times the gap count, plus a rise/fall compensation count that comes in on its own port. The period is split into a low phase (half the period, rounded up) and a high phase (the rest). The master logic that drives SDA and shifts the data uses the single-cycle `scl_rise` and `scl_fall` ticks to know when SCL changes.

A transfer starts with a `go` pulse. SCL is held high while a programmable first-bit setup delay runs, which lets SDA settle ahead of the first SCL edge. When the delay ends, `first_edge` and `scl_fall` pulse together and the free-running low/high cycle begins. A `halt` pulse returns the block to idle, with SCL high. Writing a new configuration while the block is running restarts the prescaler and the phase counter at the start of a low phase.

The controller has four states. IDLE: SCL high, no ticks. SETUP: SCL high while the setup delay is counted. LOW: SCL low. HIGH: SCL high. The transitions are:
- IDLE→SETUP on `go`.
- SETUP→LOW when the delay expires (`first_edge` and `scl_fall`).
- LOW→HIGH when the low count expires (`scl_rise`).
- HIGH→LOW when the high count expires (`scl_fall`).
- Any state→IDLE on `halt`.
- Any state→SETUP on `go`.
- SETUP, LOW or HIGH→LOW on a configuration write (restart).

Top module: `scl_clkgen`

## Requirements
- R1: After reset the block is idle: `scl_hi` is 1 and `scl_rise`, `scl_fall` and `first_edge` are 0.
- R2: The prescale field `cfg_din[2:0]` (value C) makes the internal step advance once every C+1 peripheral clock cycles. The prescaler counter is restarted by `go` and by a configuration write.
- R3: The gap field `cfg_din[8:3]` (value G) and `comp_cnt` (value K) set the period P = 20 + 8·G + K internal steps. This is the distance between successive `scl_rise` pulses, up to the largest setting G=63, K=63 (P=587).
- R4: The low phase (`scl_fall` to `scl_rise`) lasts ceil(P/2) steps. The high phase (`scl_rise` to `scl_fall`) lasts P − ceil(P/2) steps.
- R5: After a `go` pulse, SCL stays high (`scl_hi`=1) for `setup_sel`+2 internal steps. At the end of that delay, `first_edge` and `scl_fall` pulse together in the same cycle. A setting of 15 gives 17 steps.
- R6: A configuration write while the block is running restarts at the start of a low phase. `scl_hi` goes to 0 and no `scl_fall` occurs before the next `scl_rise`, which comes ceil(P/2)·(C+1) cycles after the write, where P and C are the newly written values.
- R7: `halt` forces IDLE. No tick follows, `scl_hi` stays 1, and `halt` takes priority over a simultaneous `go`.
- R8: A configuration write while idle does not start the block: no tick appears.
- R9: `scl_rise` and `scl_fall` are never high in the same cycle, and each tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_din | input | 9 | Configuration word: [2:0] prescale, [8:3] gap |
| comp_cnt | input | 6 | Rise/fall compensation count, in internal steps |
| setup_sel | input | 4 | First-bit setup delay select (delay = value + 2 steps) |
| go | input | 1 | Start pulse: enter the setup delay |
| halt | input | 1 | Stop pulse: return to idle |
| scl_hi | output | 1 | Current SCL level (1 = released high) |
| scl_rise | output | 1 | One-cycle tick: SCL goes low to high |
| scl_fall | output | 1 | One-cycle tick: SCL goes high to low |
| first_edge | output | 1 | One-cycle tick: setup delay over, first SCL fall |

## Verification
The assertions check these rules on every cycle:
- Ticks agree with the state they enter.
- A rise and a fall never coincide.
- `halt` always lands in IDLE.
- A running configuration write always lands at the start of LOW.
- The prescaler wraps to zero after each step and never passes its divisor.

Only the bench scenarios show the actual lengths: the setup delay, the low and high phases, and the period, measured in clock cycles across several prescale, gap and compensation settings, including the largest. The bench also shows that no tick appears after `halt` or after a write in idle.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] div_sel,
    output logic             step_en
);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q == div_sel) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign step_en = (cnt_q == div_sel) && !restart;

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (cnt_q == '0)); // R2
    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_sel); // R2

endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc #(
    parameter int GAP_W    = 6,
    parameter int COMP_W   = 6,
    parameter int BASE_CNT = 20,
    parameter int GAP_STEP = 8,
    parameter int PER_W    = 10
) (
    input  logic [GAP_W-1:0]  gap,
    input  logic [COMP_W-1:0] comp,
    output logic [PER_W-1:0]  low_len,
    output logic [PER_W-1:0]  high_len
);

    logic [PER_W-1:0] period;
    logic [PER_W:0]   period_up;

    always_comb begin
        period    = PER_W'(BASE_CNT) + PER_W'(gap) * PER_W'(GAP_STEP) + PER_W'(comp);
        period_up = {1'b0, period} + 1'b1;
        low_len   = period_up[PER_W:1];
        high_len  = period - low_len;
    end

endmodule

// File: rtl/scl_timing_fsm.sv
module scl_timing_fsm
    import sclgen_pkg::*;
#(
    parameter int PER_W     = 10,
    parameter int SETUP_W   = 4,
    parameter int SETUP_OFS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               go,
    input  logic               halt,
    input  logic               cfg_wr,
    input  logic [PER_W-1:0]   low_len,
    input  logic [PER_W-1:0]   high_len,
    input  logic [SETUP_W-1:0] setup_sel,
    output logic               scl_hi,
    output logic               scl_rise,
    output logic               scl_fall,
    output logic               first_edge
);

    scl_state_e       state_q, state_d;
    logic [PER_W-1:0] ph_q, ph_d;
    logic             rise_d, fall_d, first_d;
    logic [PER_W-1:0] setup_len;
    logic [PER_W:0]   ph_next;

    assign setup_len = PER_W'(setup_sel) + PER_W'(SETUP_OFS);
    assign ph_next   = {1'b0, ph_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        rise_d  = 1'b0;
        fall_d  = 1'b0;
        first_d = 1'b0;
        if (halt) begin
            state_d = ST_IDLE;
            ph_d    = '0;
        end else if (go) begin
            state_d = ST_SETUP;
            ph_d    = '0;
        end else if (cfg_wr && state_q != ST_IDLE) begin
            state_d = ST_LOW;
            ph_d    = '0;
        end else if (step_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    ph_d = '0;
                end
                ST_SETUP: begin
                    if (ph_next >= {1'b0, setup_len}) begin
                        state_d = ST_LOW;
                        ph_d    = '0;
                        fall_d  = 1'b1;
                        first_d = 1'b1;
                    end else begin
                        ph_d = ph_next[PER_W-1:0];
                    end
                end
                ST_LOW: begin
                    if (ph_next >= {1'b0, low_len}) begin
                        state_d = ST_HIGH;
                        ph_d    = '0;
                        rise_d  = 1'b1;
                    end else begin
                        ph_d = ph_next[PER_W-1:0];
                    end
                end
                ST_HIGH: begin
                    if (ph_next >= {1'b0, high_len}) begin
                        state_d = ST_LOW;
                        ph_d    = '0;
                        fall_d  = 1'b1;
                    end else begin
                        ph_d = ph_next[PER_W-1:0];
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    ph_d    = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_rise   <= 1'b0;
            scl_fall   <= 1'b0;
            first_edge <= 1'b0;
        end else begin
            scl_rise   <= rise_d;
            scl_fall   <= fall_d;
            first_edge <= first_d;
        end
    end

    assign scl_hi = (state_q != ST_LOW);

    AST_RISE_ENTERS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (state_q == ST_HIGH)); // R4
    AST_FALL_ENTERS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (state_q == ST_LOW)); // R3
    AST_FIRST_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        first_edge |-> ($past(state_q) == ST_SETUP && scl_fall)); // R5
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall)); // R9
    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == ST_IDLE && !scl_rise && !scl_fall)); // R7
    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !halt && !go && state_q != ST_IDLE) |=> (state_q == ST_LOW && ph_q == '0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !go) |=> (state_q == ST_IDLE && !scl_rise)); // R8

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int PRE_W     = 3,
    parameter int GAP_W     = 6,
    parameter int COMP_W    = 6,
    parameter int SETUP_W   = 4,
    parameter int BASE_CNT  = 20,
    parameter int GAP_STEP  = 8,
    parameter int SETUP_OFS = 2,
    localparam int CFG_W    = PRE_W + GAP_W,
    localparam int MAX_PER  = BASE_CNT + ((1 << GAP_W) - 1) * GAP_STEP + (1 << COMP_W) - 1
                              + (1 << SETUP_W) + SETUP_OFS,
    localparam int PER_W    = $clog2(MAX_PER + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_din,
    input  logic [COMP_W-1:0]  comp_cnt,
    input  logic [SETUP_W-1:0] setup_sel,
    input  logic               go,
    input  logic               halt,
    output logic               scl_hi,
    output logic               scl_rise,
    output logic               scl_fall,
    output logic               first_edge
);

    logic [PRE_W-1:0] pre_q;
    logic [GAP_W-1:0] gap_q;
    logic             step_en;
    logic [PER_W-1:0] low_len, high_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            gap_q <= '0;
        end else if (cfg_wr) begin
            pre_q <= cfg_din[PRE_W-1:0];
            gap_q <= cfg_din[CFG_W-1:PRE_W];
        end
    end

    scl_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr | go),
        .div_sel (pre_q),
        .step_en (step_en)
    );

    scl_phase_calc #(
        .GAP_W    (GAP_W),
        .COMP_W   (COMP_W),
        .BASE_CNT (BASE_CNT),
        .GAP_STEP (GAP_STEP),
        .PER_W    (PER_W)
    ) u_calc (
        .gap      (gap_q),
        .comp     (comp_cnt),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_timing_fsm #(
        .PER_W     (PER_W),
        .SETUP_W   (SETUP_W),
        .SETUP_OFS (SETUP_OFS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .go         (go),
        .halt       (halt),
        .cfg_wr     (cfg_wr),
        .low_len    (low_len),
        .high_len   (high_len),
        .setup_sel  (setup_sel),
        .scl_hi     (scl_hi),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .first_edge (first_edge)
    );

endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_din = '0;
    logic [5:0] comp_cnt = '0;
    logic [3:0] setup_sel = '0;
    logic       go = 1'b0;
    logic       halt = 1'b0;
    logic       scl_hi, scl_rise, scl_fall, first_edge;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int n_rise = 0;
    int n_fall = 0;
    int n_both = 0;
    int n_b2b = 0;
    bit prev_tick = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_rise) n_rise++;
            if (scl_fall) n_fall++;
            if (scl_rise && scl_fall) n_both++;
            if ((scl_rise || scl_fall) && prev_tick) n_b2b++;
            prev_tick = scl_rise || scl_fall;
        end
    end

    scl_clkgen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_din    (cfg_din),
        .comp_cnt   (comp_cnt),
        .setup_sel  (setup_sel),
        .go         (go),
        .halt       (halt),
        .scl_hi     (scl_hi),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .first_edge (first_edge)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sel: 0 rise, 1 fall, 2 first_edge
    task automatic wait_sig(input int sel, output int at);
        at = -1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ((sel == 0 && scl_rise) || (sel == 1 && scl_fall) || (sel == 2 && first_edge)) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic write_cfg(input int cdf, input int gap, output int t);
        @(negedge clk);
        cfg_din = {gap[5:0], cdf[2:0]};
        cfg_wr  = 1'b1;
        @(negedge clk);
        t = cyc;
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_go(output int t);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        t = cyc;
        go = 1'b0;
    endtask

    task automatic t_reset;
        check(scl_hi == 1'b1, "R1 scl_hi", scl_hi, 1);
        check({scl_rise, scl_fall, first_edge} == 3'b000, "R1 ticks", {scl_rise, scl_fall, first_edge}, 0);
    endtask

    task automatic run_timing(input int cdf, input int gap, input int comp, input int sel);
        int t0, a, b, c, d, p, lo, hi;
        int sc;
        p  = 20 + 8 * gap + comp;
        lo = (p + 1) / 2;
        hi = p - lo;
        comp_cnt  = comp[5:0];
        setup_sel = sel[3:0];
        write_cfg(cdf, gap, t0);
        pulse_go(t0);
        check(scl_hi == 1'b1, "R5 scl high in setup", scl_hi, 1);
        wait_sig(2, a);
        sc = scl_fall;
        check(a - t0 == (sel + 2) * (cdf + 1), "R5 setup delay", a - t0, (sel + 2) * (cdf + 1));
        check(sc == 1, "R5 fall with first_edge", sc, 1);
        wait_sig(0, b);
        check(b - a == lo * (cdf + 1), "R4 low phase", b - a, lo * (cdf + 1));
        wait_sig(1, c);
        check(c - b == hi * (cdf + 1), "R4 high phase", c - b, hi * (cdf + 1));
        wait_sig(0, d);
        check(d - b == p * (cdf + 1), "R3 R2 period", d - b, p * (cdf + 1));
    endtask

    task automatic t_basic;
        run_timing(0, 0, 0, 15);
    endtask

    task automatic t_prescale;
        run_timing(3, 2, 5, 0);
    endtask

    task automatic t_odd;
        run_timing(1, 1, 1, 3);
    endtask

    task automatic t_max;
        run_timing(0, 63, 63, 0);
    endtask

    task automatic t_cfg_restart;
        int t, r, f0, x;
        wait_sig(0, x);
        repeat (5) @(negedge clk);
        comp_cnt = 6'd1;
        write_cfg(2, 0, t);
        f0 = n_fall;
        check(scl_hi == 1'b0, "R6 low after write", scl_hi, 0);
        wait_sig(0, r);
        check(r - t == 11 * 3, "R6 restart to rise", r - t, 33);
        check(n_fall == f0, "R6 no fall before rise", n_fall - f0, 0);
    endtask

    task automatic t_halt;
        int r0, f0;
        @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        r0 = n_rise;
        f0 = n_fall;
        repeat (300) @(negedge clk);
        check(n_rise == r0 && n_fall == f0, "R7 no ticks after halt", n_rise + n_fall - r0 - f0, 0);
        check(scl_hi == 1'b1, "R7 scl high after halt", scl_hi, 1);
        @(negedge clk);
        halt = 1'b1;
        go   = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        go   = 1'b0;
        repeat (300) @(negedge clk);
        check(n_rise == r0 && n_fall == f0 && !first_edge, "R7 halt beats go", n_rise + n_fall - r0 - f0, 0);
    endtask

    task automatic t_idle_cfg;
        int t, r0, f0;
        r0 = n_rise;
        f0 = n_fall;
        write_cfg(0, 0, t);
        repeat (300) @(negedge clk);
        check(n_rise == r0 && n_fall == f0, "R8 idle write no ticks", n_rise + n_fall - r0 - f0, 0);
        check(scl_hi == 1'b1, "R8 idle scl high", scl_hi, 1);
    endtask

    task automatic t_tick_shape;
        check(n_both == 0, "R9 rise and fall together", n_both, 0);
        check(n_b2b == 0, "R9 tick wider than one cycle", n_b2b, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_cfg();
        t_basic();
        t_prescale();
        t_odd();
        t_cfg_restart();
        t_halt();
        t_max();
        t_tick_shape();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule